// File: doc/BRIEF.md
# Shared-Timer Input Debounce Bank

This block cleans up a bank of slow external inputs, such as buttons, jumpers and presence lines, before the rest of the chip sees them. Every pin passes through a two-stage synchronizer. After that, each input-capable pin either goes straight out or passes through a stability filter. The filter moves the clean level only after the new level has stayed unchanged for a programmed number of clock cycles.

The bank does not give each pin its own length register. It keeps three shared period registers instead, and each pin picks one of them with a 2-bit code. The two bits of that code live in two separate per-pin select words. The word at 0x00 carries the upper bit and the word at 0x04 carries the lower bit, so software can set or clear one pin's choice with a read-modify-write of each word. The same simple, always-ready write/read port reaches the three period registers. The filter counts in cycles of `clk`.

Top module: `shared_deglitch_bank`

## Requirements
- R1: After reset, both select words and all three period registers read back as zero, every pin is in pass-through mode, and every clean output is 0 while the raw inputs are 0.
- R2: A pin's code is {bit i of the word at 0x00, bit i of the word at 0x04}. Code 0 is pass-through, and codes 1, 2 and 3 use period registers 1, 2 and 3.
- R3: Period registers 1, 2 and 3 sit at 0x50, 0x54 and 0x58, hold 32 bits each and read back what was written. Any other address reads 0, and a write there changes nothing.
- R4: In pass-through mode, a change on a raw input appears on its clean output after exactly two clock edges.
- R5: With a nonzero code and a period P ≥ 1, the clean output takes a new level at the edge where the synchronized input has held that level for P cycles. With the settings used here, that is edge 2+P after the raw change.
- R6: A return of the synchronized input to the current clean level before the period ends restarts the count from zero.
- R7: A period of 0 behaves like a period of 1, so the clean output changes at the third edge after the raw change.
- R8: Pins marked output-only by the INPUT_PINS parameter ignore their select bits and always behave as pass-through.
- R9: A write to one select word changes only that word, and a read of any mapped register returns its stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the debounce count reference |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W (8) | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| pin_raw | input | NUM_PINS (32) | Raw asynchronous pin levels |
| pin_clean | output | NUM_PINS (32) | Synchronized and debounced pin levels |

## Verification
Five pins are raised in the same cycle. One is in pass-through, one is output-only and carries a nonzero code, and three use period 0, period 1 and period 5. The edge at which each output moves shows the pass-through latency, the filter latency and the period-0 rule, each apart from the others. A ninth pin uses code 1 with only the lower select bit set, and its late transition confirms the order of the code bits. A falling edge with a one-cycle glitch back to the old level is checked at edge 7 and at edges 10 and 11, which separates a restarted count from one that keeps running. Reads of the registers, and of an unmapped address after a write to it, cover the register map and the isolation between writes.

// File: rtl/pdb_pkg.sv
package pdb_pkg;
   localparam int REG_W     = 32;
   localparam int CODE_W    = 2;
   localparam int NUM_TMR   = (1 << CODE_W) - 1;
   localparam int SEL_HI_A  = 'h00;
   localparam int SEL_LO_A  = 'h04;
   localparam int PER_BASE  = 'h50;
   localparam int PER_STEP  = 4;

   typedef logic [CODE_W-1:0] pdb_code_t;

   // byte address of period register for timer index idx (0-based)
   function automatic int per_addr(input int idx);
      return PER_BASE + PER_STEP * idx;
   endfunction
endpackage

// File: rtl/pdb_sync.sv
module pdb_sync #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] meta_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '0;
         q      <= '0;
      end else begin
         meta_q <= d;
         q      <= meta_q;
      end
   end
endmodule

// File: rtl/pdb_regs.sv
module pdb_regs
   import pdb_pkg::*;
#(
   parameter int NUM_PINS = 32,
   parameter int PER_W    = 32,
   parameter int ADDR_W   = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [ADDR_W-1:0]               addr,
   input  logic [REG_W-1:0]                wdata,
   output logic [REG_W-1:0]                rdata,
   output logic [NUM_PINS-1:0]             sel_hi,
   output logic [NUM_PINS-1:0]             sel_lo,
   output logic [NUM_TMR-1:0][PER_W-1:0]   periods
);
   localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(SEL_HI_A);
   localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(SEL_LO_A);

   logic [NUM_PINS-1:0]           sel_hi_q, sel_lo_q;
   logic [NUM_TMR-1:0][PER_W-1:0] per_q;
   logic [NUM_TMR-1:0]            per_hit;
   logic                          map_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_hi_q <= '0;
         sel_lo_q <= '0;
      end else if (wr_en) begin
         if (addr == HI_A) sel_hi_q <= wdata[NUM_PINS-1:0];
         if (addr == LO_A) sel_lo_q <= wdata[NUM_PINS-1:0];
      end
   end

   for (genvar t = 0; t < NUM_TMR; t++) begin : g_per
      assign per_hit[t] = (addr == ADDR_W'(per_addr(t)));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    per_q[t] <= '0;
         else if (wr_en && per_hit[t])  per_q[t] <= wdata[PER_W-1:0];
      end
   end

   assign map_hit = (addr == HI_A) || (addr == LO_A) || (|per_hit);

   always_comb begin
      rdata = '0;
      if (addr == HI_A) rdata[NUM_PINS-1:0] = sel_hi_q;
      if (addr == LO_A) rdata[NUM_PINS-1:0] = sel_lo_q;
      for (int t = 0; t < NUM_TMR; t++)
         if (per_hit[t]) rdata[PER_W-1:0] = per_q[t];
   end

   assign sel_hi  = sel_hi_q;
   assign sel_lo  = sel_lo_q;
   assign periods = per_q;

   // R3
   unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !map_hit) |=> ($stable(sel_hi_q) && $stable(sel_lo_q) && $stable(per_q)));

   // R9
   sel_hi_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == HI_A) |=> (sel_hi_q == $past(wdata[NUM_PINS-1:0]) && $stable(sel_lo_q)));
endmodule

// File: rtl/pdb_filter.sv
module pdb_filter #(
   parameter int PER_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             s_in,
   input  logic             bypass,
   input  logic [PER_W-1:0] period,
   output logic             q_out
);
   logic             lvl_q;
   logic [PER_W-1:0] cnt_q;
   logic             done;

   // period 0 collapses to 1 because cnt+1 >= 0 always holds
   assign done = ({1'b0, cnt_q} + (PER_W+1)'(1)) >= {1'b0, period};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= 1'b0;
         cnt_q <= '0;
      end else if (bypass || s_in == lvl_q) begin
         lvl_q <= s_in;
         cnt_q <= '0;
      end else if (done) begin
         lvl_q <= s_in;
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + PER_W'(1);
      end
   end

   assign q_out = bypass ? s_in : lvl_q;

   // R6
   hold_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bypass && s_in == lvl_q) |=> $stable(lvl_q));

   // R5
   move_to_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_q != $past(lvl_q)) |-> (lvl_q == $past(s_in)));
endmodule

// File: rtl/shared_deglitch_bank.sv
module shared_deglitch_bank
   import pdb_pkg::*;
#(
   parameter int                NUM_PINS   = 32,
   parameter int                PER_W      = 32,
   parameter int                ADDR_W     = 8,
   parameter logic [NUM_PINS-1:0] INPUT_PINS = 32'h0FFF_FFFF
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_wr,
   input  logic [ADDR_W-1:0]   cfg_addr,
   input  logic [31:0]         cfg_wdata,
   output logic [31:0]         cfg_rdata,
   input  logic [NUM_PINS-1:0] pin_raw,
   output logic [NUM_PINS-1:0] pin_clean
);
   if (NUM_PINS < 1 || NUM_PINS > REG_W) begin : g_bad_pins
      $error("NUM_PINS must be 1..32");
   end
   if (PER_W < 1 || PER_W > REG_W) begin : g_bad_per
      $error("PER_W must be 1..32");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("ADDR_W too small for register map");
   end

   logic [NUM_PINS-1:0]           sel_hi, sel_lo, pin_s;
   logic [NUM_TMR-1:0][PER_W-1:0] periods;

   pdb_regs #(.NUM_PINS(NUM_PINS), .PER_W(PER_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .addr(cfg_addr),
      .wdata(cfg_wdata), .rdata(cfg_rdata),
      .sel_hi(sel_hi), .sel_lo(sel_lo), .periods(periods)
   );

   pdb_sync #(.W(NUM_PINS)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(pin_s)
   );

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      if (INPUT_PINS[i]) begin : g_in
         pdb_code_t  code;
         logic [PER_W-1:0] per_sel;
         assign code = {sel_hi[i], sel_lo[i]};
         always_comb begin
            per_sel = '0;
            for (int t = 0; t < NUM_TMR; t++)
               if (code == pdb_code_t'(t + 1)) per_sel = periods[t];
         end
         pdb_filter #(.PER_W(PER_W)) u_flt (
            .clk(clk), .rst_n(rst_n), .s_in(pin_s[i]),
            .bypass(code == '0), .period(per_sel), .q_out(pin_clean[i])
         );
      end else begin : g_out_only
         assign pin_clean[i] = pin_s[i];
      end
   end
endmodule

// File: tb/sim_shared_deglitch_bank.sv
module sim_shared_deglitch_bank;
   localparam time TCLK = 10ns;

   typedef struct {
      string       req;
      bit          is_pin;
      logic [31:0] mask;
      logic [31:0] exp;
   } exp_t;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        cfg_wr = 0;
   logic [7:0]  cfg_addr = 0;
   logic [31:0] cfg_wdata = 0;
   logic [31:0] cfg_rdata;
   logic [31:0] pin_raw = 0;
   logic [31:0] pin_clean;

   exp_t sb_q[$];
   int   checks = 0;
   int   fails  = 0;
   bit   done   = 0;

   shared_deglitch_bank u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .pin_raw(pin_raw), .pin_clean(pin_clean)
   );

   always #(TCLK/2) clk = ~clk;

   task automatic step(input int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
      step(1);
      cfg_wr = 0;
   endtask

   task automatic push(input string req, input bit is_pin,
                       input logic [31:0] mask, input logic [31:0] exp);
      exp_t e;
      e.req = req; e.is_pin = is_pin; e.mask = mask; e.exp = exp;
      sb_q.push_back(e);
   endtask

   task automatic expect_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
      cfg_addr = a;
      push(req, 0, 32'hFFFF_FFFF, exp);
      step(1);
   endtask

   // monitor: compares queued expectations mid-cycle
   initial begin
      forever begin
         @(negedge clk);
         while (sb_q.size() > 0) begin
            exp_t e;
            logic [31:0] act;
            e = sb_q.pop_front();
            act = (e.is_pin ? pin_clean : cfg_rdata) & e.mask;
            checks++;
            if (act !== e.exp) begin
               fails++;
               $display("FAIL %s actual=%h expected=%h", e.req, act, e.exp);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   localparam logic [31:0] M = 32'h4000_010F;   // pins 0,1,2,3,8,30

   initial begin
      step(3);
      rst_n = 1;
      step(1);
      // R1 reset state
      expect_rd("R1", 8'h00, 0);
      expect_rd("R1", 8'h04, 0);
      expect_rd("R1", 8'h50, 0);
      expect_rd("R1", 8'h54, 0);
      expect_rd("R1", 8'h58, 0);
      push("R1", 1, 32'hFFFF_FFFF, 0);
      step(1);
      // R3 period map
      wr(8'h50, 32'd5);
      wr(8'h54, 32'd0);
      wr(8'h58, 32'd1);
      wr(8'h10, 32'hFFFF_FFFF);
      expect_rd("R3", 8'h50, 32'd5);
      expect_rd("R3", 8'h58, 32'd1);
      expect_rd("R3", 8'h10, 0);
      wr(8'h54, 32'hDEAD_BEEF);
      expect_rd("R3", 8'h54, 32'hDEAD_BEEF);
      wr(8'h54, 32'd0);
      // R2/R9 select words: pin0 code1, pin1 code2, pin2 code3, pin30 code3
      wr(8'h00, 32'h4000_0006);
      wr(8'h04, 32'h4000_0005);
      expect_rd("R9", 8'h00, 32'h4000_0006);
      wr(8'h04, 32'h4000_0105);           // RMW: add pin8 code1
      expect_rd("R9", 8'h04, 32'h4000_0105);
      expect_rd("R9", 8'h00, 32'h4000_0006);
      // rising edge on pins 0,1,2,3,8,30
      pin_raw = M;
      step(1);
      push("R4", 1, M, 0);
      step(1);
      push("R4 R8", 1, M, 32'h4000_0008);
      step(1);
      push("R7", 1, M, 32'h4000_000E);
      step(3);
      push("R5 R2", 1, M, 32'h4000_000E);
      step(1);
      push("R5 R2", 1, M, M);
      step(2);
      // falling edge on pin0 with glitch back high
      pin_raw[0] = 0;
      step(3);
      pin_raw[0] = 1;
      step(1);
      pin_raw[0] = 0;
      step(3);
      push("R6", 1, 32'h1, 32'h1);        // edge 7: no flip after restart
      step(3);
      push("R6", 1, 32'h1, 32'h1);        // edge 10
      step(1);
      push("R6", 1, 32'h1, 32'h0);        // edge 11
      step(2);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule